// File: doc/BRIEF.md
# Masked Lane-Local Vector Interleave Unit

This datapath unit builds one 512-bit vector of 32-bit elements from two source vectors. The vector is split into 128-bit lanes. Inside each lane it keeps only the two lowest elements of each source and alternates them: first-source element, second-source element, first-source element, second-source element. The upper two elements of each lane in both sources are dropped. Before the interleave, the second source can be replaced by copies of its lowest 32-bit element.

After the interleave, a per-element write mask picks the elements that take the new value. Each unselected element either keeps its old destination value (merging) or becomes zero (zeroing). Active length is 128, 256 or 512 bits. In the encoded modes every bit above that length is cleared. Legacy mode works differently. The old destination stands in for the first source, the length is fixed at 128 bits, no mask applies, and the bits above 128 keep their old value.

The result is registered and appears one clock after an accepted request, with a valid flag that follows the request flag.

Top module: `vec_lane_zip`

## Requirements
- R1: In each 128-bit lane with lane base element L, the output elements L, L+1, L+2 and L+3 are source1[L], source2[L], source1[L+1] and source2[L+1]. Source elements L+2 and L+3 never reach the output.
- R2: `len_sel` encoding sets the active element count: 2'b00 gives 4, 2'b01 gives 8, 2'b10 gives 16, and 2'b11 also gives 16. In encoded mode (`legacy_mode`=0), every output element at or above the active count is zero.
- R3: In encoded mode with `bcast_en`=1, every second-source element used by the interleave equals `src_b[31:0]`.
- R4: An active element takes the interleaved value when `mask_en`=0, or when its `elem_mask` bit (bit j for element j) is 1.
- R5: With `mask_en`=1 and `zero_mode`=0, an active element whose mask bit is 0 keeps the value of `old_dest` for that element.
- R6: With `mask_en`=1 and `zero_mode`=1, an active element whose mask bit is 0 is zero.
- R7: Mask bits at positions at or above the active element count have no effect on the result.
- R8: In legacy mode (`legacy_mode`=1), the first source is `old_dest`, not `src_a`. Output bits 511:128 equal `old_dest[511:128]`. Output bits 127:0 are the unmasked interleave. `len_sel`, `elem_mask`, `mask_en`, `zero_mode` and `bcast_en` have no effect.
- R9: `result` and `out_valid` update on the clock edge that samples `in_valid`=1, and `out_valid` equals `in_valid` of the previous cycle. While `in_valid`=0, `result` holds its value.
- R10: The synchronous active-high reset `rst` sets `out_valid` to 0 and `result` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Request valid; operands are sampled on this edge |
| src_a | input | 512 | First source vector (used in encoded mode) |
| src_b | input | 512 | Second source vector |
| old_dest | input | 512 | Prior destination value; first source in legacy mode |
| elem_mask | input | 16 | Per-element write mask, bit j for element j |
| len_sel | input | 2 | Vector length select (00=128, 01=256, 1x=512) |
| legacy_mode | input | 1 | 1 selects legacy behaviour |
| bcast_en | input | 1 | Replicate `src_b[31:0]` across the second source |
| mask_en | input | 1 | Apply `elem_mask` |
| zero_mode | input | 1 | 1 zeroes masked-off elements, 0 merges them |
| out_valid | output | 1 | Result valid |
| result | output | 512 | Registered result vector |

## Verification
Every result and valid flag is due exactly one rising edge after the edge that accepts the request. No other register lies on the path. The bench drives operands on a falling edge and reads `result` and `out_valid` on the next falling edge, half a period after the single capturing edge. Checks for holding and reset work the same way: the stimulus is applied on one falling edge, and the outputs are compared on the following falling edge.

// File: rtl/vzip_pkg.sv
package vzip_pkg;

    typedef enum logic [1:0] {
        LEN_Q   = 2'b00,
        LEN_H   = 2'b01,
        LEN_F   = 2'b10,
        LEN_FX  = 2'b11
    } len_e;

    typedef struct packed {
        logic legacy;
        logic bcast;
        logic mask_en;
        logic zero;
    } ctrl_t;

endpackage

// File: rtl/vzip_src_prep.sv
module vzip_src_prep
    import vzip_pkg::*;
#(
    parameter int ELEM_W    = 32,
    parameter int MAX_ELEMS = 16,
    localparam int DATA_W   = ELEM_W * MAX_ELEMS
) (
    input  logic [DATA_W-1:0] src_a,
    input  logic [DATA_W-1:0] src_b,
    input  logic [DATA_W-1:0] old_dest,
    input  ctrl_t             ctrl,
    output logic [DATA_W-1:0] op1,
    output logic [DATA_W-1:0] op2
);

    logic use_bcast;
    assign use_bcast = ctrl.bcast && !ctrl.legacy;

    // Legacy mode reads the first operand from the destination.
    assign op1 = ctrl.legacy ? old_dest : src_a;

    for (genvar e = 0; e < MAX_ELEMS; e++) begin : g_op2
        assign op2[e*ELEM_W +: ELEM_W] =
            use_bcast ? src_b[ELEM_W-1:0] : src_b[e*ELEM_W +: ELEM_W];
    end

endmodule

// File: rtl/vzip_interleave.sv
module vzip_interleave #(
    parameter int ELEM_W     = 32,
    parameter int LANE_ELEMS = 4,
    parameter int MAX_ELEMS  = 16,
    localparam int DATA_W    = ELEM_W * MAX_ELEMS,
    localparam int LANES     = MAX_ELEMS / LANE_ELEMS
) (
    input  logic [DATA_W-1:0] op1,
    input  logic [DATA_W-1:0] op2,
    output logic [DATA_W-1:0] zipped
);

    // Per lane: even slots draw from op1, odd slots from op2, both
    // taken from the lower half of the lane.
    for (genvar ln = 0; ln < LANES; ln++) begin : g_lane
        for (genvar p = 0; p < LANE_ELEMS; p++) begin : g_slot
            localparam int DST = ln * LANE_ELEMS + p;
            localparam int SRC = ln * LANE_ELEMS + p / 2;
            if (p % 2 == 0) begin : g_even
                assign zipped[DST*ELEM_W +: ELEM_W] = op1[SRC*ELEM_W +: ELEM_W];
            end else begin : g_odd
                assign zipped[DST*ELEM_W +: ELEM_W] = op2[SRC*ELEM_W +: ELEM_W];
            end
        end
    end

endmodule

// File: rtl/vzip_mask_stage.sv
module vzip_mask_stage
    import vzip_pkg::*;
#(
    parameter int ELEM_W     = 32,
    parameter int LANE_ELEMS = 4,
    parameter int MAX_ELEMS  = 16,
    localparam int DATA_W    = ELEM_W * MAX_ELEMS
) (
    input  logic [DATA_W-1:0]    zipped,
    input  logic [DATA_W-1:0]    old_dest,
    input  logic [MAX_ELEMS-1:0] elem_mask,
    input  logic [MAX_ELEMS-1:0] elem_act,
    input  ctrl_t                ctrl,
    output logic [DATA_W-1:0]    merged
);

    for (genvar e = 0; e < MAX_ELEMS; e++) begin : g_elem
        logic [ELEM_W-1:0] new_v;
        logic [ELEM_W-1:0] old_v;
        logic              take;

        assign new_v = zipped[e*ELEM_W +: ELEM_W];
        assign old_v = old_dest[e*ELEM_W +: ELEM_W];
        assign take  = !ctrl.mask_en || elem_mask[e];

        always_comb begin
            if (ctrl.legacy) begin
                merged[e*ELEM_W +: ELEM_W] = (e < LANE_ELEMS) ? new_v : old_v;
            end else if (!elem_act[e]) begin
                merged[e*ELEM_W +: ELEM_W] = '0;
            end else if (take) begin
                merged[e*ELEM_W +: ELEM_W] = new_v;
            end else if (ctrl.zero) begin
                merged[e*ELEM_W +: ELEM_W] = '0;
            end else begin
                merged[e*ELEM_W +: ELEM_W] = old_v;
            end
        end
    end

endmodule

// File: rtl/vec_lane_zip.sv
module vec_lane_zip
    import vzip_pkg::*;
#(
    parameter int ELEM_W    = 32,
    parameter int LANE_W    = 128,
    parameter int VLEN_MAX  = 512,
    localparam int MAX_ELEMS  = VLEN_MAX / ELEM_W,
    localparam int LANE_ELEMS = LANE_W / ELEM_W,
    localparam int CNT_W      = $clog2(MAX_ELEMS + 1)
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      in_valid,
    input  logic [VLEN_MAX-1:0]       src_a,
    input  logic [VLEN_MAX-1:0]       src_b,
    input  logic [VLEN_MAX-1:0]       old_dest,
    input  logic [MAX_ELEMS-1:0]      elem_mask,
    input  logic [1:0]                len_sel,
    input  logic                      legacy_mode,
    input  logic                      bcast_en,
    input  logic                      mask_en,
    input  logic                      zero_mode,
    output logic                      out_valid,
    output logic [VLEN_MAX-1:0]       result
);

    typedef struct packed {
        logic                vld;
        logic [VLEN_MAX-1:0] data;
    } state_t;

    ctrl_t               ctrl;
    logic [CNT_W-1:0]    n_act;
    logic [MAX_ELEMS-1:0] elem_act;
    logic [VLEN_MAX-1:0] op1, op2, zipped, merged;
    state_t              st_d, st_q;

    assign ctrl = '{legacy: legacy_mode, bcast: bcast_en,
                    mask_en: mask_en, zero: zero_mode};

    always_comb begin
        case (len_e'(len_sel))
            LEN_Q:   n_act = CNT_W'(LANE_ELEMS);
            LEN_H:   n_act = CNT_W'(2 * LANE_ELEMS);
            default: n_act = CNT_W'(MAX_ELEMS);
        endcase
        for (int e = 0; e < MAX_ELEMS; e++) begin
            elem_act[e] = (CNT_W'(e) < n_act);
        end
    end

    vzip_src_prep #(.ELEM_W(ELEM_W), .MAX_ELEMS(MAX_ELEMS)) u_prep (
        .src_a    (src_a),
        .src_b    (src_b),
        .old_dest (old_dest),
        .ctrl     (ctrl),
        .op1      (op1),
        .op2      (op2)
    );

    vzip_interleave #(.ELEM_W(ELEM_W), .LANE_ELEMS(LANE_ELEMS),
                      .MAX_ELEMS(MAX_ELEMS)) u_zip (
        .op1    (op1),
        .op2    (op2),
        .zipped (zipped)
    );

    vzip_mask_stage #(.ELEM_W(ELEM_W), .LANE_ELEMS(LANE_ELEMS),
                      .MAX_ELEMS(MAX_ELEMS)) u_mask (
        .zipped    (zipped),
        .old_dest  (old_dest),
        .elem_mask (elem_mask),
        .elem_act  (elem_act),
        .ctrl      (ctrl),
        .merged    (merged)
    );

    always_comb begin
        st_d     = st_q;
        st_d.vld = in_valid;
        if (in_valid) begin
            st_d.data = merged;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid = st_q.vld;
    assign result    = st_q.data;

endmodule

// File: rtl/vzip_chk.sv
module vzip_chk #(
    parameter int DATA_W = 512,
    parameter int MASK_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic [DATA_W-1:0] src_b,
    input logic [DATA_W-1:0] old_dest,
    input logic [MASK_W-1:0] elem_mask,
    input logic [1:0]        len_sel,
    input logic              legacy_mode,
    input logic              bcast_en,
    input logic              mask_en,
    input logic              zero_mode,
    input logic              out_valid,
    input logic [DATA_W-1:0] result
);

    // R9
    valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    // R9
    valid_drop_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    // R9
    result_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(result));

    // R2
    upper_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !legacy_mode && len_sel == 2'b00) |=> (result[DATA_W-1:128] == '0));

    // R8
    legacy_upper_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && legacy_mode) |=> (result[DATA_W-1:128] == $past(old_dest[DATA_W-1:128])));

    // R8
    legacy_src1_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && legacy_mode) |=> (result[31:0] == $past(old_dest[31:0])));

    // R6
    zero_fill_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !legacy_mode && mask_en && zero_mode && !elem_mask[0])
        |=> (result[31:0] == '0));

    // R5
    merge_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !legacy_mode && mask_en && !zero_mode && !elem_mask[1])
        |=> (result[63:32] == $past(old_dest[63:32])));

    // R3
    bcast_fill_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !legacy_mode && bcast_en && (!mask_en || elem_mask[3]))
        |=> (result[127:96] == $past(src_b[31:0])));

endmodule

bind vec_lane_zip vzip_chk #(.DATA_W(VLEN_MAX), .MASK_W(MAX_ELEMS)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .in_valid    (in_valid),
    .src_b       (src_b),
    .old_dest    (old_dest),
    .elem_mask   (elem_mask),
    .len_sel     (len_sel),
    .legacy_mode (legacy_mode),
    .bcast_en    (bcast_en),
    .mask_en     (mask_en),
    .zero_mode   (zero_mode),
    .out_valid   (out_valid),
    .result      (result)
);

// File: tb/sim_vec_lane_zip.sv
`timescale 1ns/1ps
module sim_vec_lane_zip;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         in_valid = 1'b0;
    logic [511:0] src_a = '0, src_b = '0, old_dest = '0;
    logic [15:0]  elem_mask = '0;
    logic [1:0]   len_sel = '0;
    logic         legacy_mode = 1'b0, bcast_en = 1'b0, mask_en = 1'b0, zero_mode = 1'b0;
    logic         out_valid;
    logic [511:0] result;

    int n_chk  = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    vec_lane_zip u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid),
        .src_a(src_a), .src_b(src_b), .old_dest(old_dest),
        .elem_mask(elem_mask), .len_sel(len_sel), .legacy_mode(legacy_mode),
        .bcast_en(bcast_en), .mask_en(mask_en), .zero_mode(zero_mode),
        .out_valid(out_valid), .result(result)
    );

    function automatic int active_n(input logic [1:0] ls);
        return (ls == 2'b00) ? 4 : (ls == 2'b01) ? 8 : 16;
    endfunction

    // Expected element e, from the requirements.
    function automatic logic [31:0] ref_elem(input int e);
        int lane = e / 4;
        int pos  = e % 4;
        int idx  = lane * 4 + pos / 2;
        logic [31:0] s1 = legacy_mode ? old_dest[idx*32 +: 32] : src_a[idx*32 +: 32];
        logic [31:0] s2 = (bcast_en && !legacy_mode) ? src_b[31:0] : src_b[idx*32 +: 32];
        logic [31:0] nv = (pos % 2 == 0) ? s1 : s2;
        if (legacy_mode) return (e < 4) ? nv : old_dest[e*32 +: 32];
        if (e >= active_n(len_sel)) return 32'h0;
        if (!mask_en || elem_mask[e]) return nv;
        return zero_mode ? 32'h0 : old_dest[e*32 +: 32];
    endfunction

    function automatic string tag_of(input int e);
        if (legacy_mode) return "R8";
        if (e >= active_n(len_sel)) return "R2";
        if (mask_en && !elem_mask[e]) return zero_mode ? "R6" : "R5";
        if (bcast_en && (e % 2 == 1)) return "R3";
        if (mask_en) return "R4";
        return "R1";
    endfunction

    task automatic check_vec(input logic [511:0] exp_v, input string tag);
        for (int e = 0; e < 16; e++) begin
            n_chk++;
            if (result[e*32 +: 32] !== exp_v[e*32 +: 32]) begin
                n_fail++;
                $display("FAIL %s elem %0d: got %h expected %h", tag, e,
                         result[e*32 +: 32], exp_v[e*32 +: 32]);
            end
        end
    endtask

    task automatic check_bit(input logic got, input logic exp_b, input string tag);
        n_chk++;
        if (got !== exp_b) begin
            n_fail++;
            $display("FAIL %s valid: got %b expected %b", tag, got, exp_b);
        end
    endtask

    task automatic randomize_data();
        for (int e = 0; e < 16; e++) begin
            src_a[e*32 +: 32]    = {8'hA0, 8'(e), 16'($urandom)};
            src_b[e*32 +: 32]    = {8'hB0, 8'(e), 16'($urandom)};
            old_dest[e*32 +: 32] = {8'hD0, 8'(e), 16'($urandom)};
        end
    endtask

    // Drive on a falling edge, read on the next falling edge.
    task automatic run_op(input string force_tag);
        logic [511:0] exp_v;
        @(negedge clk);
        in_valid = 1'b1;
        for (int e = 0; e < 16; e++) exp_v[e*32 +: 32] = ref_elem(e);
        @(negedge clk);
        check_bit(out_valid, 1'b1, "R9");
        if (force_tag != "") begin
            check_vec(exp_v, force_tag);
        end else begin
            for (int e = 0; e < 16; e++) begin
                n_chk++;
                if (result[e*32 +: 32] !== exp_v[e*32 +: 32]) begin
                    n_fail++;
                    $display("FAIL %s elem %0d: got %h expected %h", tag_of(e), e,
                             result[e*32 +: 32], exp_v[e*32 +: 32]);
                end
            end
        end
        in_valid = 1'b0;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin : stim
        logic [511:0] held;
        logic [15:0]  masks [6];

        // R10: reset state
        repeat (3) @(negedge clk);
        check_bit(out_valid, 1'b0, "R10");
        check_vec('0, "R10");
        rst = 1'b0;

        // Full sweep over mode, length, broadcast, masking and mask patterns.
        for (int cfg = 0; cfg < 64; cfg++) begin
            masks[0] = 16'h0000; masks[1] = 16'hFFFF; masks[2] = 16'hAAAA;
            masks[3] = 16'h5555; masks[4] = 16'($urandom); masks[5] = 16'($urandom);
            for (int p = 0; p < 6; p++) begin
                legacy_mode = cfg[0];
                len_sel     = cfg[2:1];
                bcast_en    = cfg[3];
                mask_en     = cfg[4];
                zero_mode   = cfg[5];
                elem_mask   = masks[p];
                randomize_data();
                run_op("");
            end
        end

        // R1: plain interleave, distinct element tags, full length
        legacy_mode = 0; len_sel = 2'b10; bcast_en = 0; mask_en = 0; zero_mode = 0;
        randomize_data();
        run_op("R1");

        // R2: encoding 2'b11 acts as full length
        len_sel = 2'b11;
        randomize_data();
        run_op("R2");

        // R7: mask bits above the active count are ignored
        len_sel = 2'b00; mask_en = 1; zero_mode = 1; elem_mask = 16'hFFF0;
        randomize_data();
        run_op("R7");
        len_sel = 2'b01; zero_mode = 0; elem_mask = 16'hFF05;
        randomize_data();
        run_op("R7");

        // R8: legacy ignores length, mask and broadcast controls
        legacy_mode = 1; len_sel = 2'b10; bcast_en = 1; mask_en = 1; zero_mode = 1;
        elem_mask = 16'h0000;
        randomize_data();
        run_op("R8");

        // R9: result holds while in_valid is low
        held = result;
        @(negedge clk);
        legacy_mode = 0; mask_en = 0; randomize_data();
        @(negedge clk);
        check_bit(out_valid, 1'b0, "R9");
        check_vec(held, "R9");

        // R10: reset after activity clears the outputs
        legacy_mode = 0; len_sel = 2'b10; mask_en = 0; bcast_en = 0;
        randomize_data();
        run_op("R1");
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check_bit(out_valid, 1'b0, "R10");
        check_vec('0, "R10");
        rst = 1'b0;

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule